// File: doc/BRIEF.md
# Bit-Serial I2C Line Controller

This block gives a CPU direct, one-bit-at-a-time control of an I2C bus. Software writes a small configuration word that enables a slave role, a master role, or both. It then handles every bit on the bus through a ready flag. Each synchronized rising edge of SCL captures the bus SDA level into a receive bit and raises the ready flag, which also drives an attention output. While the flag is up and SCL is low, the block holds SCL low, so the bus waits for software. The only limit on how long software may take is an external timeout strobe.

Software answers by writing a control word. That word either carries the next SDA bit or asks the block to end mastership with a stop condition. A new SDA bit reaches the line only while the synchronized SCL is low. A bit written while SCL is still high waits until SCL falls. When mastership is requested, the block sends a start condition. If the bus is busy, it first waits for a stop. It then clocks SCL itself, holding each phase until a minimum-time strobe from a separate timing block arrives. A bus monitor detects start and stop conditions and keeps a bus-busy flag.

Top module: `i2c_bitlink`

## Requirements
- R1: After reset, `cfg_rd` reads 00h, `scl_oe` and `sda_oe` are 0, and `rdy` and `bus_busy` are 0. Configuration bit 0 is slave enable and bit 1 is master request. All other configuration bits read 0.
- R2: While configuration bits 0 and 1 are both 0, the block never drives `scl_oe` or `sda_oe`, and SCL edges do not set `rdy`.
- R3: SDA falling while SCL is high gives a one-cycle `start_seen` pulse and sets `bus_busy`. SDA rising while SCL is high gives a one-cycle `stop_seen` pulse and clears `bus_busy`. Each pulse appears two clock edges after the pin change, and `bus_busy` follows one edge later.
- R4: When the block is enabled, a rising SCL pin sets `rdy` (and `attn`) on the third clock edge after the change. At the same time, `rx_bit` takes the SDA level.
- R5: While `rdy` is 1 and the synchronized SCL is low, `scl_oe` is 1. A control write clears `rdy` on the next edge and releases the stretch.
- R6: A control write with bit 1 clear queues bit 0 as the SDA value (0 pulls low). The value reaches `sda_oe` only while the synchronized SCL is low. A write made while SCL is low shows on the second edge. A write made while SCL is high is held until SCL has been seen low, and then shows on the third edge after the SCL pin falls.
- R7: Setting master request on an idle bus pulls SDA low with SCL released on the second edge after the write (start). On the edge after a minimum-time strobe, SCL is pulled low and `rdy` is set.
- R8: A master request made while `bus_busy` is 1 drives nothing until a stop is detected. SDA is then pulled low on the fourth edge after the SDA pin rises.
- R9: Without the `tmin_i` strobe, the master never moves between its start, low, high and stop phases.
- R10: A control write with bit 1 set makes the master pull SDA low while SCL is low, then release SCL, and then release SDA (stop). Master request then clears.
- R11: A `timeout_i` pulse clears slave enable and master request on the next edge and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rd | output | CFG_W | Configuration read value |
| ctl_we | input | 1 | Control write strobe (services `rdy`) |
| ctl_wdata | input | CTL_W | Control data: bit 0 SDA value, bit 1 stop request |
| rdy | output | 1 | Per-bit data-ready flag |
| attn | output | 1 | Attention / interrupt request |
| rx_bit | output | 1 | SDA level captured at the last SCL rise |
| bus_busy | output | 1 | Bus is between a start and a stop |
| start_seen | output | 1 | One-cycle start-condition pulse |
| stop_seen | output | 1 | One-cycle stop-condition pulse |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| tmin_i | input | 1 | Minimum-phase-time strobe |
| timeout_i | input | 1 | Bus timeout strobe |

## Verification
Every pin change passes through two synchronizer flops, so the bench counts edges from the falling clock edge where it moves a pin. Condition pulses are due on the second edge. Ready, busy and an SCL-gated SDA update are due on the third. A deferred start is due on the fourth. Register writes take effect on the first edge. For each timed result, the bench samples one cycle early to show the old value and then at the exact due cycle, always half a period away from the active edge. Sweeps cover both received bit values and all four combinations of written value and SCL phase at the moment of the write.

// File: rtl/i2c_bitlink_pkg.sv
package i2c_bitlink_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_WAIT_BUS,
        M_START,
        M_LOW,
        M_HIGH,
        M_STOP_A,
        M_STOP_B
    } mst_state_e;

    typedef struct packed {
        logic       slave_en;
        logic       master_req;
        logic       rdy;
        logic       rx_bit;
        logic       tx_pend;
        logic       tx_val;
        logic       tx_bit;
        logic       stop_pend;
        mst_state_e state;
    } core_regs_t;

    localparam int CFG_SLAVE_BIT  = 0;
    localparam int CFG_MASTER_BIT = 1;
    localparam int CTL_TX_BIT     = 0;
    localparam int CTL_STOP_BIT   = 1;

    localparam core_regs_t CORE_RST = '{
        slave_en:   1'b0,
        master_req: 1'b0,
        rdy:        1'b0,
        rx_bit:     1'b0,
        tx_pend:    1'b0,
        tx_val:     1'b1,
        tx_bit:     1'b1,
        stop_pend:  1'b0,
        state:      M_IDLE
    };

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_d, chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[TOP-1:0], din};
        end else begin : g_single
            always_comb chain_d = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[TOP];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic start_p,
    output logic stop_p,
    output logic busy
);
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic busy;
    } det_regs_t;

    det_regs_t r_q, r_d;
    logic      scl_held_high;

    always_comb begin
        scl_held_high = scl_s & r_q.scl_prev;
        scl_rise      = scl_s & ~r_q.scl_prev;
        start_p       = scl_held_high & r_q.sda_prev & ~sda_s;
        stop_p        = scl_held_high & ~r_q.sda_prev & sda_s;
        r_d           = r_q;
        r_d.scl_prev  = scl_s;
        r_d.sda_prev  = sda_s;
        if (start_p)     r_d.busy = 1'b1;
        else if (stop_p) r_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, busy: 1'b0};
        else        r_q <= r_d;
    end

    assign busy = r_q.busy;

    p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> busy);
    p_busy_off_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !busy);
endmodule

// File: rtl/i2c_bitlink.sv
module i2c_bitlink
    import i2c_bitlink_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CFG_W       = 8,
    parameter int CTL_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rd,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic             rdy,
    output logic             attn,
    output logic             rx_bit,
    output logic             bus_busy,
    output logic             start_seen,
    output logic             stop_seen,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             tmin_i,
    input  logic             timeout_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_s;
    logic              scl_s, sda_s, scl_rise, start_p, stop_p, busy;
    logic              unused_wbits;

    assign line_raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_sync
            i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (line_raw[g]),
                .dout (line_s[g])
            );
        end
    endgenerate

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2c_cond_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .start_p (start_p),
        .stop_p  (stop_p),
        .busy    (busy)
    );

    core_regs_t r_q, r_d;
    logic       en_q, en_d, set_rdy, mst_scl_low, mst_sda_low;

    always_comb begin
        r_d     = r_q;
        set_rdy = 1'b0;

        if (cfg_we) begin
            r_d.slave_en   = cfg_wdata[CFG_SLAVE_BIT];
            r_d.master_req = cfg_wdata[CFG_MASTER_BIT];
        end

        unique case (r_q.state)
            M_IDLE:
                if (r_q.master_req) r_d.state = busy ? M_WAIT_BUS : M_START;
            M_WAIT_BUS:
                if (!busy) r_d.state = M_START;
            M_START:
                if (tmin_i) begin
                    r_d.state  = M_LOW;
                    r_d.tx_bit = 1'b0;
                    set_rdy    = 1'b1;
                end
            M_LOW:
                if (tmin_i && !r_q.rdy && !scl_s && !r_q.tx_pend) begin
                    if (r_q.stop_pend) begin
                        r_d.state     = M_STOP_A;
                        r_d.stop_pend = 1'b0;
                    end else begin
                        r_d.state = M_HIGH;
                    end
                end
            M_HIGH:
                if (tmin_i && scl_s) r_d.state = M_LOW;
            M_STOP_A:
                if (tmin_i && !scl_s) r_d.state = M_STOP_B;
            M_STOP_B:
                if (tmin_i && scl_s) begin
                    r_d.state      = M_IDLE;
                    r_d.master_req = 1'b0;
                end
            default: r_d.state = M_IDLE;
        endcase

        if (ctl_we) r_d.rdy = 1'b0;
        if (scl_rise || set_rdy) r_d.rdy = 1'b1;
        if (scl_rise) r_d.rx_bit = sda_s;

        if (ctl_we) begin
            if (ctl_wdata[CTL_STOP_BIT]) begin
                r_d.stop_pend = 1'b1;
            end else begin
                r_d.tx_pend = 1'b1;
                r_d.tx_val  = ctl_wdata[CTL_TX_BIT];
            end
        end else if (r_q.tx_pend && !scl_s) begin
            r_d.tx_bit  = r_q.tx_val;
            r_d.tx_pend = 1'b0;
        end

        if (timeout_i) r_d = CORE_RST;

        if (!r_d.master_req) begin
            r_d.state     = M_IDLE;
            r_d.stop_pend = 1'b0;
        end

        en_d = r_d.slave_en | r_d.master_req;
        if (!en_d) begin
            r_d.rdy     = 1'b0;
            r_d.tx_pend = 1'b0;
            r_d.tx_bit  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CORE_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        en_q        = r_q.slave_en | r_q.master_req;
        mst_scl_low = (r_q.state == M_LOW) || (r_q.state == M_STOP_A);
        mst_sda_low = (r_q.state == M_START) || (r_q.state == M_STOP_A) ||
                      (r_q.state == M_STOP_B);
        scl_oe      = mst_scl_low | (en_q & r_q.rdy & ~scl_s);
        sda_oe      = mst_sda_low | (en_q & ~r_q.tx_bit);
        cfg_rd                 = '0;
        cfg_rd[CFG_SLAVE_BIT]  = r_q.slave_en;
        cfg_rd[CFG_MASTER_BIT] = r_q.master_req;
    end

    assign rdy          = r_q.rdy;
    assign attn         = r_q.rdy;
    assign rx_bit       = r_q.rx_bit;
    assign bus_busy     = busy;
    assign start_seen   = start_p;
    assign stop_seen    = stop_p;
    assign unused_wbits = ^{cfg_wdata, ctl_wdata};

    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (r_q.state == M_IDLE && !r_q.rdy && !scl_oe && !sda_oe));

    p_timeout_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> (!r_q.slave_en && !r_q.master_req));

    p_tx_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !$stable(r_q.tx_bit) && $past(r_q.state) != M_START)
        |-> !$past(scl_s));

    p_rdy_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rdy) |-> ($past(scl_rise) || $past(r_q.state) == M_START));

    p_tmin_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != $past(r_q.state) && r_q.state != M_IDLE &&
         $past(r_q.state) != M_IDLE && $past(r_q.state) != M_WAIT_BUS)
        |-> $past(tmin_i));
endmodule

// File: tb/i2c_bitlink_tb_top.sv
`timescale 1ns/1ps
module i2c_bitlink_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, ctl_we = 1'b0;
    logic [7:0] cfg_wdata = '0, ctl_wdata = '0, cfg_rd;
    logic       rdy, attn, rx_bit, bus_busy, start_seen, stop_seen;
    logic       scl_oe, sda_oe, scl_i, sda_i;
    logic       tmin_i = 1'b0, timeout_i = 1'b0;
    logic       tb_scl_pull = 1'b0, tb_sda_pull = 1'b0;
    int         checks = 0, errors = 0, stop_cnt = 0, stop_base;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign scl_i = !(scl_oe || tb_scl_pull);
    assign sda_i = !(sda_oe || tb_sda_pull);

    i2c_bitlink dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rd(cfg_rd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rdy(rdy),
        .attn(attn), .rx_bit(rx_bit), .bus_busy(bus_busy),
        .start_seen(start_seen), .stop_seen(stop_seen), .scl_i(scl_i),
        .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .tmin_i(tmin_i),
        .timeout_i(timeout_i)
    );

    always @(negedge clk) if (stop_seen) stop_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 cfg_rd", cfg_rd, 8'h00);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 rdy", rdy, 0);
        chk("R1 bus_busy", bus_busy, 0);
        wr_cfg(8'hFC);
        chk("R1 unused cfg bits", cfg_rd, 8'h00);

        // R2 disabled: SCL edges leave rdy low and lines free
        tb_scl_pull = 1'b1; tick(4);
        tb_scl_pull = 1'b0; tick(5);
        chk("R2 rdy", rdy, 0);
        chk("R2 scl_oe", scl_oe, 0);
        chk("R2 sda_oe", sda_oe, 0);

        // R4 sweep over received bit value, slave role
        wr_cfg(8'h01);
        chk("R1 cfg_rd slave", cfg_rd, 8'h01);
        for (int b = 0; b < 2; b++) begin
            tb_scl_pull = 1'b1; tick(3);
            tb_sda_pull = (b == 0); tick(3);
            tb_scl_pull = 1'b0;
            tick(2);
            chk("R4 rdy early", rdy, 0);
            tick(1);
            chk("R4 rdy", rdy, 1);
            chk("R4 attn", attn, 1);
            chk("R4 rx_bit", rx_bit, b);
            wr_ctl(8'h01);
            tick(2);
        end
        tb_scl_pull = 1'b1; tick(3);
        tb_sda_pull = 1'b0; tick(3);
        tb_scl_pull = 1'b0; tick(5);
        wr_ctl(8'h01); tick(2);

        // R5 clock stretch
        tb_scl_pull = 1'b1; tick(4);
        tb_scl_pull = 1'b0; tick(4);
        chk("R5 rdy before stretch", rdy, 1);
        tb_scl_pull = 1'b1; tick(4);
        chk("R5 stretch on", scl_oe, 1);
        tb_scl_pull = 1'b0; tick(4);
        chk("R5 stretch held", scl_oe, 1);
        chk("R5 scl pin low", scl_i, 0);
        wr_ctl(8'h01);
        chk("R5 stretch released", scl_oe, 0);
        tick(5);
        wr_ctl(8'h01); tick(2);

        // R6 sweep: written value x SCL phase at write time
        for (int v = 0; v < 2; v++) begin
            for (int hi = 0; hi < 2; hi++) begin
                tb_scl_pull = 1'b1; tick(4);
                wr_ctl(v ? 8'h00 : 8'h01); tick(4);
                chk("R6 primed", sda_oe, v);
                if (hi != 0) begin
                    tb_scl_pull = 1'b0; tick(5);
                    wr_ctl(v[7:0]); tick(5);
                    chk("R6 held while SCL high", sda_oe, v);
                    tb_scl_pull = 1'b1;
                    tick(2);
                    chk("R6 not yet", sda_oe, v);
                    tick(1);
                    chk("R6 applied after SCL low", sda_oe, !v);
                end else begin
                    wr_ctl(v[7:0]);
                    chk("R6 low write pending", sda_oe, v);
                    tick(1);
                    chk("R6 low write applied", sda_oe, !v);
                end
                wr_ctl(8'h01); tick(3);
                tb_scl_pull = 1'b0; tick(5);
                wr_ctl(8'h01); tick(2);
            end
        end

        // R3 start and stop detection
        chk("R3 idle", bus_busy, 0);
        tb_sda_pull = 1'b1;
        tick(1);
        chk("R3 start early", start_seen, 0);
        tick(1);
        chk("R3 start pulse", start_seen, 1);
        tick(1);
        chk("R3 start one cycle", start_seen, 0);
        chk("R3 busy set", bus_busy, 1);
        tb_sda_pull = 1'b0;
        tick(2);
        chk("R3 stop pulse", stop_seen, 1);
        tick(1);
        chk("R3 busy cleared", bus_busy, 0);
        wr_cfg(8'h00); tick(2);

        // R7 / R9 master start without and with the strobe
        wr_cfg(8'h02);
        tick(1);
        chk("R7 start sda", sda_oe, 1);
        chk("R7 start scl free", scl_oe, 0);
        tick(10);
        chk("R9 no strobe sda", sda_oe, 1);
        chk("R9 no strobe scl", scl_oe, 0);
        chk("R9 no strobe rdy", rdy, 0);
        chk("R7 own start busy", bus_busy, 1);
        tmin_i = 1'b1; tick(1); tmin_i = 1'b0;
        chk("R7 scl low", scl_oe, 1);
        chk("R7 rdy", rdy, 1);
        chk("R7 sda held", sda_oe, 1);
        tick(10);
        chk("R9 low phase held", scl_oe, 1);

        // R10 stop
        stop_base = stop_cnt;
        wr_ctl(8'h02);
        tmin_i = 1'b1; tick(20); tmin_i = 1'b0;
        chk("R10 master cleared", cfg_rd, 8'h00);
        chk("R10 scl free", scl_oe, 0);
        chk("R10 sda free", sda_oe, 0);
        chk("R10 stop seen", stop_cnt > stop_base, 1);
        chk("R10 bus idle", bus_busy, 0);

        // R8 deferral while busy
        tb_sda_pull = 1'b1; tick(4);
        chk("R8 busy", bus_busy, 1);
        wr_cfg(8'h02); tick(10);
        chk("R8 deferred sda", sda_oe, 0);
        chk("R8 deferred scl", scl_oe, 0);
        tb_sda_pull = 1'b0;
        tick(3);
        chk("R8 not yet", sda_oe, 0);
        tick(1);
        chk("R8 start after stop", sda_oe, 1);

        // R11 timeout
        timeout_i = 1'b1; tick(1); timeout_i = 1'b0;
        chk("R11 cfg cleared", cfg_rd, 8'h00);
        chk("R11 sda free", sda_oe, 0);
        chk("R11 scl free", scl_oe, 0);
        tick(5);
        wr_cfg(8'h01);
        timeout_i = 1'b1; tick(1); timeout_i = 1'b0;
        chk("R11 slave cleared", cfg_rd, 8'h00);
        tick(3);
        finish_run();
    end
endmodule